// File: doc/BRIEF.md
# 16-bit Execution Unit with Equality Flag

This block is the combinational arithmetic and logic stage of a small 16-bit load/store processor. It takes two 16-bit operands and a 3-bit operation select, and returns one 16-bit result for one of seven operations: addition, subtraction, signed set-less-than, bitwise OR, AND and XOR, and load-upper. Load and store address calculation uses the addition operation.

Alongside the result it always drives an equality flag that says whether the two operands are equal. Branch-if-equal and branch-if-not-equal logic upstream reads this flag directly. The flag does not depend on the selected operation. Choosing the operands, extending immediates and writing results back to registers are handled outside this block.

The block holds no state. It has no state register, no states and no transitions. Every output follows the current inputs within the same cycle.

Top module: `alu16_core`

## Requirements
- R1: With select code 0 (add), result equals op_a + op_b modulo 2^16. There is no overflow indication.
- R2: With select code 1 (subtract), result equals op_a - op_b modulo 2^16.
- R3: With select code 2 (set-less-than), both operands are treated as two's-complement signed values. The result is exactly 0x0001 when op_a < op_b and 0x0000 otherwise. This holds when the internal difference overflows, for example 0x8000 against 0x0001 gives 0x0001.
- R4: With select code 3, result is the bitwise OR of op_a and op_b.
- R5: With select code 4, result is the bitwise AND of op_a and op_b.
- R6: With select code 5, result is the bitwise XOR of op_a and op_b.
- R7: With select code 6 (load-upper), result bits 15:8 equal op_b bits 7:0 and result bits 7:0 are zero. op_a and op_b bits 15:8 have no effect on the result.
- R8: The equal output is 1 exactly when op_a equals op_b, for every select code.
- R9: The unused select code 7 yields a result of 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; supplies the byte for load-upper |
| op_sel | input | 3 | Operation select, codes 0 to 7 |
| result | output | 16 | Result of the selected operation |
| equal | output | 1 | High when op_a equals op_b |

## Verification
The block has no internal state, so a fault always shows up in the same evaluation as the input that exposes it. A broken carry link gives a wrong sum or difference only for operand pairs whose carries pass through that bit. Random pairs, together with directed all-ones and sign-boundary values, reach those carry paths. A faulty overflow correction in the signed compare only shows when the operand signs differ and the difference wraps. For that reason the directed cases pair 0x8000 and 0x7FFF with small values of both signs.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int SEL_W  = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SLT  = 3'd2,
        OP_OR   = 3'd3,
        OP_AND  = 3'd4,
        OP_XOR  = 3'd5,
        OP_LUI  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b_eff[i]   = b[i] ^ sub;
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    // signed overflow: carry into MSB differs from carry out of it
    assign ovf = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y_or,
    output logic [W-1:0] y_and,
    output logic [W-1:0] y_xor
);
    assign y_or  = a | b;
    assign y_and = a & b;
    assign y_xor = a ^ b;
endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         diff_msb,
    input  logic         diff_ovf,
    output logic         eq,
    output logic         lt
);
    // equality from a direct XOR-reduce, independent of the adder
    assign eq = ~|(a ^ b);
    // signed less-than: sign of difference, corrected on overflow
    assign lt = diff_msb ^ diff_ovf;
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [SEL_W-1:0] op_sel,
    output logic [W-1:0]     result,
    output logic             equal
);
    localparam int LOW_W = W - BW;

    alu_op_e     op;
    logic        do_sub;
    logic [W-1:0] sum;
    logic        ovf;
    logic [W-1:0] y_or, y_and, y_xor;
    logic        lt;

    assign op     = alu_op_e'(op_sel);
    assign do_sub = (op == OP_SUB) || (op == OP_SLT);

    alu16_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(op_b), .sub(do_sub), .sum(sum), .ovf(ovf)
    );

    alu16_logic #(.W(W)) u_logic (
        .a(op_a), .b(op_b), .y_or(y_or), .y_and(y_and), .y_xor(y_xor)
    );

    alu16_cmp #(.W(W)) u_cmp (
        .a(op_a), .b(op_b), .diff_msb(sum[W-1]), .diff_ovf(ovf),
        .eq(equal), .lt(lt)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:  result = sum;
            OP_SLT:  result = {{(W-1){1'b0}}, lt};
            OP_OR:   result = y_or;
            OP_AND:  result = y_and;
            OP_XOR:  result = y_xor;
            OP_LUI:  result = {op_b[BW-1:0], {LOW_W{1'b0}}};
            OP_NONE: result = '0;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic [W-1:0]     op_a,
    input logic [W-1:0]     op_b,
    input logic [SEL_W-1:0] op_sel,
    input logic [W-1:0]     result,
    input logic             equal
);
    logic [W-1:0] ref_sum;
    logic [W-1:0] ref_diff;
    assign ref_sum  = op_a + op_b;
    assign ref_diff = op_a - op_b;

    always_comb begin
        if (op_sel == 3'd0) AST_ADD_WRAP: assert (result == ref_sum);                        // R1
        if (op_sel == 3'd1) AST_SUB_WRAP: assert (result == ref_diff);                       // R2
        if (op_sel == 3'd2) AST_SLT_BOOL: assert (result[W-1:1] == '0);                      // R3
        if (op_sel == 3'd2) AST_SLT_SIGN: assert (result[0] == ($signed(op_a) < $signed(op_b))); // R3
        if (op_sel == 3'd6) AST_LUI_LOW:  assert (result[7:0] == 8'h00);                     // R7
        if (op_sel == 3'd7) AST_SEL_IDLE: assert (result == '0);                             // R9
        AST_EQ_FLAG: assert (equal == (op_a == op_b));                                       // R8
    end
endmodule

bind alu16_core alu16_checker #(.W(W)) u_chk (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result), .equal(equal)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [15:0] result;
    logic        equal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    alu16_core uut (
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result), .equal(equal)
    );

    function automatic logic [15:0] exp_res(input logic [2:0] s, input logic [15:0] a, input logic [15:0] b);
        case (s)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return ($signed(a) < $signed(b)) ? 16'h0001 : 16'h0000;
            3'd3: return a | b;
            3'd4: return a & b;
            3'd5: return a ^ b;
            3'd6: return {b[7:0], 8'h00};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [2:0] s, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_sel = s; op_a = a; op_b = b;
        #1;
        total++;
        if (result !== exp_res(s, a, b)) begin
            bad++;
            $display("FAIL %s sel=%0d a=%h b=%h result=%h expected=%h",
                     req_of(s), s, a, b, result, exp_res(s, a, b));
        end
        total++;
        if (equal !== (a == b)) begin
            bad++;
            $display("FAIL R8 sel=%0d a=%h b=%h equal=%b expected=%b", s, a, b, equal, (a == b));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20011));
        // initial all-zero inputs: add of zeros, flag set
        apply(3'd0, 16'h0000, 16'h0000);                 // R1, R8
        // R1 wrap
        apply(3'd0, 16'hFFFF, 16'h0001);
        apply(3'd0, 16'h8000, 16'h8000);
        // R2 wrap
        apply(3'd1, 16'h0000, 16'h0001);
        apply(3'd1, 16'h1234, 16'h1234);
        // R3 overflow corners
        apply(3'd2, 16'h8000, 16'h0001);
        apply(3'd2, 16'h7FFF, 16'hFFFF);
        apply(3'd2, 16'hFFFF, 16'h7FFF);
        apply(3'd2, 16'h0001, 16'h8000);
        apply(3'd2, 16'h8000, 16'h7FFF);
        apply(3'd2, 16'h4444, 16'h4444);
        // R4 R5 R6
        apply(3'd3, 16'hF0F0, 16'h0FF0);
        apply(3'd4, 16'hF0F0, 16'h0FF0);
        apply(3'd5, 16'hFFFF, 16'hFFFF);
        // R7: upper byte of op_b and op_a ignored
        apply(3'd6, 16'hFFFF, 16'hABCD);
        apply(3'd6, 16'h0000, 16'h00CD);
        // R9
        apply(3'd7, 16'hFFFF, 16'h1234);
        // R8 across every select with equal operands
        for (int s = 0; s < 8; s++) apply(3'(s), 16'h5A5A, 16'h5A5A);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = ($urandom % 8 == 0) ? ra : 16'($urandom);
            apply(3'($urandom % 8), ra, rb);
        end
        finish_run();
    end
endmodule